// File: doc/BRIEF.md
# ADC Sequence Status and Flag Controller

This block holds the status state that runs beside a successive-approximation converter sequencer. A 3-bit position counter steps through a sequence of four or eight conversions. The counter value is the index of the result register that will be written next. Each accepted conversion-done strobe sets the completion flag for the current position, captures the converter's SAR value and advances the counter. A sequence-complete flag reports the end of a single sequence. In continuous scan it reports the end of the first sequence only.

Software uses a small byte-wide register bus to start sequences and read status. In special mode it can also write the flags directly and reach a test window onto the SAR value. Result-register reads arrive from the neighbouring result file as a strobe plus an index. Two clearing policies are available. Under fast clear, a result read clears that result's flag and the sequence flag at once. Under the default policy, a flag clears only when a status read saw it set before the result read.

Top module: `adc_seq_flags`

## Requirements
- R1: After reset, the counter, all eight completion flags, the sequence-complete flag and the SAR value read as zero, and no sequence is active.
- R2: Each accepted conversion-done strobe increments the counter. The counter wraps to 0 after count 3 when `seq_len8`=0 and after count 7 when `seq_len8`=1. It does not wrap at 4 in eight-conversion mode.
- R3: A bus write to address 4 starts a sequence in either mode: the counter goes to 0, all completion flags clear, and the sequence becomes active. A done strobe in the same cycle is discarded. With `fast_clr`=0 the start also clears the sequence-complete flag.
- R4: Done strobes are ignored (counter, flags and SAR unchanged) while no sequence is active. This holds before the first start and after a single sequence (`scan_cont`=0) ends. The end of a single sequence sets the sequence-complete flag.
- R5: With `scan_cont`=1 the counter continues into the next sequence after wrapping. The sequence-complete flag sets only at the end of the first sequence after a start.
- R6: An accepted done strobe sets the completion flag whose index equals the counter value before the strobe. If a clear and a set hit the same flag in one cycle, the flag ends set.
- R7: With `fast_clr`=1 a result read clears the selected flag with no status read needed, and it also clears the sequence-complete flag.
- R8: With `fast_clr`=0 a result read clears the selected flag only if a status read (address 0 or 1) happened after that flag was set. The sequence-complete flag is not cleared by result reads.
- R9: Address 0 reads {seq-complete in bit 7, zeros in bits 6:3, counter in bits 2:0}. Address 1 reads flag i in bit i. Writes to addresses 0 and 1 are ignored in normal mode. In special mode, a write to address 0 sets the sequence-complete flag to data bit 7, and a write to address 1 loads the flags from the data byte.
- R10: In special mode, address 2 reads and writes SAR bits 9:2 and address 3 reads and writes SAR bits 1:0 in data bits 7:6, with bits 5:0 reading 0. In normal mode both addresses read 0 and writes to them are ignored.
- R11: An accepted done strobe loads the SAR value from `sar_in`. A special-mode test write in the same cycle overrides only the bits it targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | Enables direct status writes and the test window |
| fast_clr | input | 1 | Selects clear-on-result-read policy |
| scan_cont | input | 1 | 1 = continuous scan, 0 = single sequence |
| seq_len8 | input | 1 | 1 = eight conversions per sequence, 0 = four |
| conv_done | input | 1 | Conversion-done strobe from the sequencer |
| sar_in | input | 10 | SAR value from the converter |
| res_rd | input | 1 | Result-register read strobe |
| res_sel | input | 3 | Index of the result register read |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| seq_done | output | 1 | Sequence-complete flag |
| conv_cnt | output | 3 | Conversion position counter |
| cc_flags | output | 8 | Completion flags, one per result register |

## Verification
A wrong counter value shows up one clock later in two places: the counter field at address 0, and a completion flag set at the wrong index. Every done strobe that follows repeats the error. A lost or spurious status-read arming does not show at once. It shows only when a later result read under the default policy fails to clear a flag, or clears one it should not. For that reason the vectors place result reads both before and after status reads, and around flags that were set after the last status read. SAR capture errors show only through the test window in special mode, so that window is read back after every load and write case.

// File: rtl/adc_flag_pkg.sv
package adc_flag_pkg;
    localparam int NCH   = 8;
    localparam int CNT_W = 3;
    localparam int SAR_W = 10;
    localparam int DW    = 8;
    localparam int AW    = 3;

    localparam logic [AW-1:0] ADDR_STAT_HI = 3'd0;
    localparam logic [AW-1:0] ADDR_STAT_LO = 3'd1;
    localparam logic [AW-1:0] ADDR_TEST_HI = 3'd2;
    localparam logic [AW-1:0] ADDR_TEST_LO = 3'd3;
    localparam logic [AW-1:0] ADDR_START   = 3'd4;
endpackage

// File: rtl/adc_seq_track.sv
module adc_seq_track #(
    parameter int CNT_W = adc_flag_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic             len8,
    input  logic             cont,
    input  logic             fast_clr,
    input  logic             res_rd,
    input  logic             scf_wr,
    input  logic             scf_wval,
    output logic [CNT_W-1:0] cnt,
    output logic             scf,
    output logic             acc
);
    localparam logic [CNT_W-1:0] LAST8 = '1;
    localparam logic [CNT_W-1:0] LAST4 = LAST8 >> 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
        logic             first;
        logic             scf;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [CNT_W-1:0] last;
    logic wrap;

    always_comb begin
        last = len8 ? LAST8 : LAST4;
        acc  = done && st_q.active && !start;
        wrap = acc && (st_q.cnt >= last);
        st_d = st_q;
        if (start) begin
            st_d.cnt    = '0;
            st_d.active = 1'b1;
            st_d.first  = 1'b1;
            if (!fast_clr) st_d.scf = 1'b0;
        end else begin
            if (fast_clr && res_rd) st_d.scf = 1'b0;
            if (scf_wr) st_d.scf = scf_wval;
            if (acc) begin
                st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
                if (wrap) begin
                    st_d.first = 1'b0;
                    if (!cont) st_d.active = 1'b0;
                    if (st_q.first) st_d.scf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign scf = st_q.scf;

    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && st_q.cnt >= last) |=> (st_q.cnt == '0));
    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.cnt == '0 && st_q.active));
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && !start) |=> $stable(st_q.cnt));
    a_r5_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.scf) |-> ($past(st_q.first) || $past(scf_wr)));
endmodule

// File: rtl/adc_cc_flags.sv
module adc_cc_flags #(
    parameter int NCH = adc_flag_pkg::NCH,
    parameter int IW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_stb,
    input  logic [IW-1:0]  set_idx,
    input  logic           clr_all,
    input  logic           fast_clr,
    input  logic           stat_rd,
    input  logic           res_rd,
    input  logic [IW-1:0]  res_sel,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_val,
    output logic [NCH-1:0] flags
);
    typedef struct packed {
        logic [NCH-1:0] flags;
        logic [NCH-1:0] armed;
    } cc_st_t;

    cc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all) begin
            st_d.flags = '0;
            st_d.armed = '0;
        end else begin
            if (stat_rd) st_d.armed = st_q.armed | st_q.flags;
            if (res_rd && (fast_clr || st_q.armed[res_sel])) begin
                st_d.flags[res_sel] = 1'b0;
                st_d.armed[res_sel] = 1'b0;
            end
            if (wr_en) begin
                st_d.flags = wr_val;
                st_d.armed = st_d.armed & wr_val;
            end
            if (set_stb) begin
                st_d.flags[set_idx] = 1'b1;
                st_d.armed[set_idx] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_stb && set_idx == g) |=> st_q.flags[g]);
        a_r7_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (fast_clr && res_rd && res_sel == g && !(set_stb && set_idx == g)
             && !wr_en && !clr_all) |=> !st_q.flags[g]);
        a_r8_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
            (!fast_clr && res_rd && res_sel == g && !st_q.armed[g] && st_q.flags[g]
             && !wr_en && !clr_all) |=> st_q.flags[g]);
    end
endmodule

// File: rtl/adc_sar_window.sv
module adc_sar_window #(
    parameter int SAR_W = adc_flag_pkg::SAR_W,
    parameter int DW    = adc_flag_pkg::DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SAR_W-1:0] sar_in,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [DW-1:0]    wdata,
    output logic [SAR_W-1:0] sar
);
    localparam int LO_W = SAR_W - DW;

    typedef struct packed {
        logic [SAR_W-1:0] sar;
    } sar_st_t;

    sar_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)  st_d.sar = sar_in;
        if (wr_hi) st_d.sar[SAR_W-1 -: DW] = wdata;
        if (wr_lo) st_d.sar[LO_W-1:0] = wdata[DW-1 -: LO_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sar = st_q.sar;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !wr_hi && !wr_lo) |=> $stable(st_q.sar));
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_hi && !wr_lo) |=> (st_q.sar == $past(sar_in)));
endmodule

// File: rtl/adc_seq_flags.sv
module adc_seq_flags #(
    parameter int NCH   = adc_flag_pkg::NCH,
    parameter int CNT_W = adc_flag_pkg::CNT_W,
    parameter int SAR_W = adc_flag_pkg::SAR_W,
    parameter int DW    = adc_flag_pkg::DW,
    parameter int AW    = adc_flag_pkg::AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             special_mode,
    input  logic             fast_clr,
    input  logic             scan_cont,
    input  logic             seq_len8,
    input  logic             conv_done,
    input  logic [SAR_W-1:0] sar_in,
    input  logic             res_rd,
    input  logic [CNT_W-1:0] res_sel,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             seq_done,
    output logic [CNT_W-1:0] conv_cnt,
    output logic [NCH-1:0]   cc_flags
);
    import adc_flag_pkg::*;

    localparam int LO_W = SAR_W - DW;

    logic wr_any, rd_any, sp_wr;
    logic start, stat_rd, scf_wr, flg_wr, hi_wr, lo_wr, acc;
    logic [SAR_W-1:0] sar;

    always_comb begin
        wr_any  = bus_en && bus_wr;
        rd_any  = bus_en && !bus_wr;
        sp_wr   = wr_any && special_mode;
        start   = wr_any && (bus_addr == ADDR_START);
        stat_rd = rd_any && (bus_addr == ADDR_STAT_HI || bus_addr == ADDR_STAT_LO);
        scf_wr  = sp_wr && (bus_addr == ADDR_STAT_HI);
        flg_wr  = sp_wr && (bus_addr == ADDR_STAT_LO);
        hi_wr   = sp_wr && (bus_addr == ADDR_TEST_HI);
        lo_wr   = sp_wr && (bus_addr == ADDR_TEST_LO);
    end

    adc_seq_track #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(conv_done),
        .len8(seq_len8), .cont(scan_cont), .fast_clr(fast_clr),
        .res_rd(res_rd), .scf_wr(scf_wr), .scf_wval(bus_wdata[DW-1]),
        .cnt(conv_cnt), .scf(seq_done), .acc(acc)
    );

    adc_cc_flags #(.NCH(NCH), .IW(CNT_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_stb(acc), .set_idx(conv_cnt),
        .clr_all(start), .fast_clr(fast_clr), .stat_rd(stat_rd),
        .res_rd(res_rd), .res_sel(res_sel), .wr_en(flg_wr),
        .wr_val(bus_wdata[NCH-1:0]), .flags(cc_flags)
    );

    adc_sar_window #(.SAR_W(SAR_W), .DW(DW)) u_sar (
        .clk(clk), .rst_n(rst_n), .load(acc), .sar_in(sar_in),
        .wr_hi(hi_wr), .wr_lo(lo_wr), .wdata(bus_wdata), .sar(sar)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STAT_HI: bus_rdata = {seq_done, {(DW-1-CNT_W){1'b0}}, conv_cnt};
            ADDR_STAT_LO: bus_rdata = cc_flags;
            ADDR_TEST_HI: if (special_mode) bus_rdata = sar[SAR_W-1 -: DW];
            ADDR_TEST_LO: if (special_mode) bus_rdata = {sar[LO_W-1:0], {(DW-LO_W){1'b0}}};
            default:      bus_rdata = '0;
        endcase
    end

    a_r9_normal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!special_mode && !start && !conv_done && !res_rd) |=> $stable(cc_flags));
endmodule

// File: tb/sim_adc_seq_flags.sv
module sim_adc_seq_flags;
    logic clk = 1'b0, rst_n = 1'b0;
    logic special_mode = 0, fast_clr = 0, scan_cont = 0, seq_len8 = 0, conv_done = 0;
    logic [9:0] sar_in = '0;
    logic res_rd = 0;
    logic [2:0] res_sel = '0;
    logic bus_en = 0, bus_wr = 0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic seq_done;
    logic [2:0] conv_cnt;
    logic [7:0] cc_flags;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    adc_seq_flags u0 (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .fast_clr(fast_clr),
        .scan_cont(scan_cont), .seq_len8(seq_len8), .conv_done(conv_done),
        .sar_in(sar_in), .res_rd(res_rd), .res_sel(res_sel), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .seq_done(seq_done), .conv_cnt(conv_cnt), .cc_flags(cc_flags)
    );

    // op: 0 done, 1 start, 2 status read, 3 result read
    // row = {op[1:0], arg[2:0], flags[7:0], cnt[2:0], scf}
    localparam logic [16:0] VEC [15] = '{
        {2'd1, 3'd0, 8'h00, 3'd0, 1'b0},  // R3 start
        {2'd0, 3'd0, 8'h01, 3'd1, 1'b0},  // R6
        {2'd0, 3'd0, 8'h03, 3'd2, 1'b0},  // R2
        {2'd3, 3'd0, 8'h03, 3'd2, 1'b0},  // R8 no status read yet
        {2'd2, 3'd0, 8'h03, 3'd2, 1'b0},  // R8 status read
        {2'd3, 3'd0, 8'h02, 3'd2, 1'b0},  // R8 clears
        {2'd0, 3'd0, 8'h06, 3'd3, 1'b0},  // R6
        {2'd3, 3'd2, 8'h06, 3'd3, 1'b0},  // R8 set after status read
        {2'd0, 3'd0, 8'h0E, 3'd0, 1'b1},  // R4 end of single sequence
        {2'd0, 3'd0, 8'h0E, 3'd0, 1'b1},  // R4 ignored
        {2'd2, 3'd0, 8'h0E, 3'd0, 1'b1},
        {2'd3, 3'd1, 8'h0C, 3'd0, 1'b1},
        {2'd3, 3'd2, 8'h08, 3'd0, 1'b1},
        {2'd3, 3'd3, 8'h00, 3'd0, 1'b1},  // R8 scf kept
        {2'd1, 3'd0, 8'h00, 3'd0, 1'b0}   // R3 clears scf
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        conv_done = 0; res_rd = 0; bus_en = 0; bus_wr = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); idle_all();
    endtask

    task automatic do_op(input logic [1:0] op, input logic [2:0] arg);
        case (op)
            2'd0: conv_done = 1;
            2'd1: begin bus_en = 1; bus_wr = 1; bus_addr = 3'd4; end
            2'd2: begin bus_en = 1; bus_wr = 0; bus_addr = 3'd1; end
            default: begin res_rd = 1; res_sel = arg; end
        endcase
        step();
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        bus_en = 0; bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        special_mode = 1;
        for (int a = 0; a < 4; a++) begin
            peek(a[2:0], rd);
            chk("R1 reg", {24'd0, rd}, 32'd0);
        end
        chk("R1 outs", {20'd0, seq_done, conv_cnt, cc_flags}, 32'd0);
        special_mode = 0;
        do_op(2'd0, 3'd0);
        chk("R4 done before start", {21'd0, conv_cnt, cc_flags}, 32'd0);

        // vector table: fast_clr=0, four conversions, single sequence
        for (int i = 0; i < 15; i++) begin
            do_op(VEC[i][16:15], VEC[i][14:12]);
            chk($sformatf("R2 R6 R8 vec %0d", i), {20'd0, seq_done, conv_cnt, cc_flags},
                {20'd0, VEC[i][0], VEC[i][3:1], VEC[i][11:4]});
        end

        // R7 / R5: fast clear, continuous scan
        fast_clr = 1; scan_cont = 1;
        do_op(2'd1, 0); do_op(2'd0, 0); do_op(2'd0, 0);
        chk("R7 pre", {24'd0, cc_flags}, 32'h03);
        do_op(2'd3, 3'd0);
        chk("R7 fast clear no status read", {24'd0, cc_flags}, 32'h02);
        do_op(2'd0, 0); do_op(2'd0, 0);
        chk("R5 first sequence end", {27'd0, seq_done, conv_cnt, 1'b0}, {27'd0, 1'b1, 3'd0, 1'b0});
        chk("R5 flags", {24'd0, cc_flags}, 32'h0E);
        do_op(2'd3, 3'd1);
        chk("R7 scf cleared", {23'd0, seq_done, cc_flags}, {23'd0, 1'b0, 8'h0C});
        for (int k = 0; k < 4; k++) do_op(2'd0, 0);
        chk("R5 second sequence no scf", {20'd0, seq_done, conv_cnt, cc_flags}, {20'd0, 1'b0, 3'd0, 8'h0F});

        // R2 eight-conversion single sequence
        fast_clr = 0; scan_cont = 0; seq_len8 = 1;
        do_op(2'd1, 0);
        for (int k = 0; k < 4; k++) do_op(2'd0, 0);
        chk("R2 no wrap at 4", {29'd0, conv_cnt}, 32'd4);
        for (int k = 0; k < 4; k++) do_op(2'd0, 0);
        chk("R2 wrap at 8", {20'd0, seq_done, conv_cnt, cc_flags}, {20'd0, 1'b1, 3'd0, 8'hFF});
        do_op(2'd0, 0);
        chk("R4 ignored after end", {21'd0, conv_cnt, cc_flags}, {21'd0, 3'd0, 8'hFF});

        // R6 set wins over fast clear
        fast_clr = 1; seq_len8 = 0;
        do_op(2'd1, 0);
        conv_done = 1; res_rd = 1; res_sel = 3'd0; step();
        chk("R6 set wins", {21'd0, conv_cnt, cc_flags}, {21'd0, 3'd1, 8'h01});
        // R3 start discards same-cycle done
        conv_done = 1; bus_en = 1; bus_wr = 1; bus_addr = 3'd4; step();
        chk("R3 start with done", {21'd0, conv_cnt, cc_flags}, 32'd0);

        // R9 status writes
        special_mode = 0;
        bus_write(3'd1, 8'hAA);
        chk("R9 normal write ignored", {24'd0, cc_flags}, 32'h00);
        special_mode = 1;
        bus_write(3'd1, 8'h5A);
        chk("R9 special flag write", {24'd0, cc_flags}, 32'h5A);
        bus_write(3'd0, 8'h80);
        peek(3'd0, rd);
        chk("R9 status hi layout", {24'd0, rd}, 32'h80);
        peek(3'd1, rd);
        chk("R9 status lo layout", {24'd0, rd}, 32'h5A);

        // R10 / R11 test window
        special_mode = 0;
        do_op(2'd1, 0);
        sar_in = 10'h2B5; do_op(2'd0, 0);
        peek(3'd2, rd);
        chk("R10 normal read zero", {24'd0, rd}, 32'h00);
        special_mode = 1;
        peek(3'd2, rd);
        chk("R11 sar hi capture", {24'd0, rd}, 32'hAD);
        peek(3'd3, rd);
        chk("R11 sar lo capture", {24'd0, rd}, 32'h40);
        bus_write(3'd2, 8'h12);
        bus_write(3'd3, 8'hC0);
        peek(3'd2, rd);
        chk("R10 hi write", {24'd0, rd}, 32'h12);
        peek(3'd3, rd);
        chk("R10 lo write", {24'd0, rd}, 32'hC0);
        special_mode = 0;
        bus_write(3'd2, 8'h99);
        special_mode = 1;
        peek(3'd2, rd);
        chk("R10 normal write ignored", {24'd0, rd}, 32'h12);
        sar_in = 10'h000;
        conv_done = 1; bus_en = 1; bus_wr = 1; bus_addr = 3'd2; bus_wdata = 8'h77; step();
        peek(3'd2, rd);
        chk("R11 write beats load hi", {24'd0, rd}, 32'h77);
        peek(3'd3, rd);
        chk("R11 load keeps lo", {24'd0, rd}, 32'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule